// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit timer/counter and an 8-bit watchdog counter that share one programmable prescaler. A single assignment bit hands the prescaler to one of the two counters. The counter that does not own the prescaler advances on every one of its own ticks, with no division. The timer counts either an internal instruction-clock enable or edges on an external pin. For the external pin, a configuration bit picks rising or falling edges. The timer sets a sticky overflow flag when it wraps from FF to 00.

The same 3-bit rate code gives a different ratio to each owner. The timer sees twice the division that the watchdog sees for the same code. A write to the timer reloads it and restarts the prescaler when the timer owns it. A watchdog-clear strobe zeroes the watchdog and restarts the prescaler when the watchdog owns it.

The watchdog oscillator is modelled as a tick enable. When the watchdog count runs past FF, the block emits a one-cycle timeout pulse and the watchdog counts on from zero.

Top module: `shared_prescale_timer`

## Requirements
- R1: While reset is held and just after it is released, the timer value is 00, the overflow flag is 0 and the timeout output is 0.
- R2: With the prescaler given to the watchdog (cfgPreWdt=1) and the internal source selected (cfgSrcExt=0), the timer advances by one on every cycle in which instrTick is high.
- R3: With the prescaler given to the timer (cfgPreWdt=0), the timer advances once per 2^(k+1) source ticks, where k is the value of cfgRate. Code 0 gives 1:2 and code 7 gives 1:256.
- R4: The watchdog advances once per wdtTick when it does not own the prescaler. It advances once per 2^k wdtTicks when it owns the prescaler. Code 0 gives 1:1 and code 7 gives 1:128. When its 8-bit count steps past FF, wdtTimeout is high for exactly one cycle and the count restarts from zero.
- R5: A timer write (tmrWrEn) loads tmrWrData. While the timer owns the prescaler, the write also zeroes the prescaler count, so that a full 2^(k+1) fresh ticks are needed before the next increment.
- R6: wdtClr zeroes the watchdog count, and no timeout appears in the following cycle. While the watchdog owns the prescaler, wdtClr also zeroes the prescaler count.
- R7: With cfgSrcExt=1, cfgEdgeFall=0 counts rising edges of extPin and cfgEdgeFall=1 counts falling edges. The pin passes through two synchronising flops and an edge flop, so the timer moves at the third clock edge after the pin changes.
- R8: The overflow flag goes to 1 in the cycle the timer wraps from FF to 00 and holds until a flag write (ovfWrEn) with ovfWrData=0. A wrap in the same cycle as a clearing write leaves the flag set.
- R9: A timer write in the same cycle as an increment wins: the timer takes tmrWrData exactly.
- R10: With cfgSrcExt=1, instrTick has no effect on the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSrcExt | input | 1 | 1: count extPin edges, 0: count instrTick |
| cfgEdgeFall | input | 1 | 1: falling edges of extPin, 0: rising edges |
| cfgPreWdt | input | 1 | Prescaler owner, 1: watchdog, 0: timer |
| cfgRate | input | 3 | Prescaler rate code |
| instrTick | input | 1 | Internal instruction-clock enable |
| extPin | input | 1 | Asynchronous external count input |
| wdtTick | input | 1 | Watchdog oscillator tick enable |
| tmrWrEn | input | 1 | Timer write strobe |
| tmrWrData | input | 8 | Timer write value |
| ovfWrEn | input | 1 | Overflow flag write strobe |
| ovfWrData | input | 1 | Overflow flag write value |
| wdtClr | input | 1 | Watchdog clear strobe |
| tmrValue | output | 8 | Current timer count |
| ovfFlag | output | 1 | Sticky timer overflow flag |
| wdtTimeout | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The properties assume that every input holds a known value from the release of reset onward. They also assume that tmrWrData is valid in any cycle in which tmrWrEn is high, because the load check compares the timer against the previous cycle's data. The bench meets both assumptions by driving every input to a defined level before reset is released. It changes inputs only on the falling clock edge, and it raises wdtClr only in cycles with no watchdog tick.

// File: rtl/spt_pkg.sv
package spt_pkg;

  // Strobes passed from the control block to the datapath each cycle
  typedef struct packed {
    logic tmrInc;    // advance the timer by one
    logic tmrLoad;   // load the timer from the write port
    logic wdtInc;    // advance the watchdog by one
    logic wdtClear;  // zero the watchdog
  } sptStrobe_t;

endpackage

// File: rtl/spt_ctrl.sv
module spt_ctrl
  import spt_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSrcExt,
  input  logic              cfgEdgeFall,
  input  logic              cfgPreWdt,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              instrTick,
  input  logic              extPin,
  input  logic              wdtTick,
  input  logic              tmrWrEn,
  input  logic              wdtClr,
  output sptStrobe_t        strobe
);

  // Largest timer ratio is 2^(2^RATE_W), so the prescaler needs 2^RATE_W bits
  localparam int PRE_W = 1 << RATE_W;
  localparam int SHF_W = RATE_W + 1;

  // ---------------- external pin conditioning ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncLvl;
  logic                   prevLvl;
  logic                   extEdge;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= extPin;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], extPin};
      end
    end
  endgenerate

  assign syncLvl = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncLvl;
  end

  always_comb begin
    if (cfgEdgeFall) extEdge = prevLvl & ~syncLvl;
    else             extEdge = syncLvl & ~prevLvl;
  end

  // ---------------- source and prescaler ----------------
  logic             srcTick;
  logic             preIn;
  logic [SHF_W-1:0] rateShift;
  logic [PRE_W:0]   fullMask;
  logic [PRE_W-1:0] preTerm;
  logic [PRE_W-1:0] preCnt;
  logic             preHit;
  logic             preClear;

  assign srcTick = cfgSrcExt ? extEdge : instrTick;
  assign preIn   = cfgPreWdt ? wdtTick : srcTick;

  // The watchdog gets 2^k, the timer gets 2^(k+1), from the same code
  always_comb begin
    if (cfgPreWdt) rateShift = SHF_W'(cfgRate);
    else           rateShift = SHF_W'(cfgRate) + SHF_W'(1);
    fullMask = ((PRE_W+1)'(1) << rateShift) - (PRE_W+1)'(1);
    preTerm  = fullMask[PRE_W-1:0];
  end

  assign preHit   = preIn && (preCnt == preTerm);
  assign preClear = (tmrWrEn && !cfgPreWdt) || (wdtClr && cfgPreWdt);

  always_ff @(posedge clk) begin
    if (!rstN)         preCnt <= '0;
    else if (preClear) preCnt <= '0;
    else if (preHit)   preCnt <= '0;
    else if (preIn)    preCnt <= preCnt + PRE_W'(1);
  end

  // ---------------- strobes to the datapath ----------------
  always_comb begin
    strobe.tmrInc   = cfgPreWdt ? srcTick : preHit;
    strobe.tmrLoad  = tmrWrEn;
    strobe.wdtInc   = cfgPreWdt ? preHit : wdtTick;
    strobe.wdtClear = wdtClr;
  end

endmodule

// File: rtl/spt_datapath.sv
module spt_datapath
  import spt_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sptStrobe_t       strobe,
  input  logic [TMR_W-1:0] tmrWrData,
  input  logic             ovfWrEn,
  input  logic             ovfWrData,
  output logic [TMR_W-1:0] tmrValue,
  output logic             ovfFlag,
  output logic             wdtTimeout
);

  logic [TMR_W-1:0] tmrReg;
  logic             tmrWrap;
  logic [WDT_W-1:0] wdtCnt;
  logic             wdtWrap;

  assign tmrWrap = strobe.tmrInc && !strobe.tmrLoad && (tmrReg == '1);
  assign wdtWrap = strobe.wdtInc && !strobe.wdtClear && (wdtCnt == '1);

  // Timer: a load beats an increment in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)               tmrReg <= '0;
    else if (strobe.tmrLoad) tmrReg <= tmrWrData;
    else if (strobe.tmrInc)  tmrReg <= tmrReg + TMR_W'(1);
  end

  // Sticky overflow flag: a wrap beats a software write
  always_ff @(posedge clk) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (tmrWrap) ovfFlag <= 1'b1;
    else if (ovfWrEn) ovfFlag <= ovfWrData;
  end

  // Watchdog counter and its one-cycle timeout pulse
  always_ff @(posedge clk) begin
    if (!rstN)                wdtCnt <= '0;
    else if (strobe.wdtClear) wdtCnt <= '0;
    else if (strobe.wdtInc)   wdtCnt <= wdtCnt + WDT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) wdtTimeout <= 1'b0;
    else       wdtTimeout <= wdtWrap;
  end

  assign tmrValue = tmrReg;

endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
  import spt_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int WDT_W       = 8,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgSrcExt,
  input  logic              cfgEdgeFall,
  input  logic              cfgPreWdt,
  input  logic [RATE_W-1:0] cfgRate,
  input  logic              instrTick,
  input  logic              extPin,
  input  logic              wdtTick,
  input  logic              tmrWrEn,
  input  logic [TMR_W-1:0]  tmrWrData,
  input  logic              ovfWrEn,
  input  logic              ovfWrData,
  input  logic              wdtClr,
  output logic [TMR_W-1:0]  tmrValue,
  output logic              ovfFlag,
  output logic              wdtTimeout
);

  sptStrobe_t strobe;

  spt_ctrl #(
    .RATE_W      (RATE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgSrcExt   (cfgSrcExt),
    .cfgEdgeFall (cfgEdgeFall),
    .cfgPreWdt   (cfgPreWdt),
    .cfgRate     (cfgRate),
    .instrTick   (instrTick),
    .extPin      (extPin),
    .wdtTick     (wdtTick),
    .tmrWrEn     (tmrWrEn),
    .wdtClr      (wdtClr),
    .strobe      (strobe)
  );

  spt_datapath #(
    .TMR_W (TMR_W),
    .WDT_W (WDT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tmrWrData  (tmrWrData),
    .ovfWrEn    (ovfWrEn),
    .ovfWrData  (ovfWrData),
    .tmrValue   (tmrValue),
    .ovfFlag    (ovfFlag),
    .wdtTimeout (wdtTimeout)
  );

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tmrWrEn,
  input logic [TMR_W-1:0] tmrWrData,
  input logic             ovfWrEn,
  input logic             ovfWrData,
  input logic             wdtClr,
  input logic [TMR_W-1:0] tmrValue,
  input logic             ovfFlag,
  input logic             wdtTimeout
);

  // R4: a timeout is never longer than one cycle
  assert_timeout_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout);

  // R6: a clear keeps the next cycle free of timeouts
  assert_clear_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> !wdtTimeout);

  // R9: a write lands exactly, even with a concurrent increment
  assert_load_exact_R9: assert property (@(posedge clk) disable iff (!rstN)
    tmrWrEn |=> (tmrValue == $past(tmrWrData)));

  // R2: without a write the timer either holds or steps by one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tmrWrEn |=> (tmrValue == $past(tmrValue)) ||
                 (tmrValue == TMR_W'($past(tmrValue) + TMR_W'(1))));

  // R8: a wrap from all ones to zero leaves the flag set
  assert_wrap_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrWrEn && (tmrValue == '1)) |=> ((tmrValue != '0) || ovfFlag));

  // R8: the flag holds without a write
  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfWrEn) |=> ovfFlag);

  // R8: a clearing write with no possible wrap clears the flag
  assert_flag_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfWrEn && !ovfWrData && (tmrValue != '1)) |=> !ovfFlag);

endmodule

bind shared_prescale_timer spt_checker u_chk (.*);

// File: tb/shared_prescale_timer_bench.sv
`timescale 1ns/1ps
module shared_prescale_timer_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cfgSrcExt, cfgEdgeFall, cfgPreWdt;
  logic [2:0] cfgRate;
  logic       instrTick, extPin, wdtTick;
  logic       tmrWrEn;
  logic [7:0] tmrWrData;
  logic       ovfWrEn, ovfWrData, wdtClr;
  logic [7:0] tmrValue;
  logic       ovfFlag, wdtTimeout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shared_prescale_timer u_shared_prescale_timer (
    .clk(clk), .rstN(rstN), .cfgSrcExt(cfgSrcExt), .cfgEdgeFall(cfgEdgeFall),
    .cfgPreWdt(cfgPreWdt), .cfgRate(cfgRate), .instrTick(instrTick),
    .extPin(extPin), .wdtTick(wdtTick), .tmrWrEn(tmrWrEn),
    .tmrWrData(tmrWrData), .ovfWrEn(ovfWrEn), .ovfWrData(ovfWrData),
    .wdtClr(wdtClr), .tmrValue(tmrValue), .ovfFlag(ovfFlag),
    .wdtTimeout(wdtTimeout)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTmr(logic [7:0] v);
    tmrWrEn = 1'b1; tmrWrData = v;
    cycles(1);
    tmrWrEn = 1'b0;
  endtask

  task automatic instrRun(int n);
    instrTick = 1'b1;
    cycles(n);
    instrTick = 1'b0;
  endtask

  task automatic clearWdt();
    wdtClr = 1'b1;
    cycles(1);
    wdtClr = 1'b0;
  endtask

  task automatic wdtRun(int n, output int pulses);
    pulses = 0;
    wdtTick = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (wdtTimeout) pulses++;
    end
    wdtTick = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 timer", tmrValue, 0);
    check("R1 flag", ovfFlag, 0);
    check("R1 timeout", wdtTimeout, 0);
  endtask

  task automatic test_direct_count();
    cfgPreWdt = 1'b1; cfgSrcExt = 1'b0;
    writeTmr(8'h00);
    instrRun(10);
    check("R2 ten ticks", tmrValue, 10);
    cycles(3);
    check("R2 idle hold", tmrValue, 10);
  endtask

  task automatic test_timer_ratio();
    cfgPreWdt = 1'b0; cfgSrcExt = 1'b0;
    cfgRate = 3'd0; writeTmr(8'h00); instrRun(7);
    check("R3 code0 1:2", tmrValue, 3);
    cfgRate = 3'd2; writeTmr(8'h00); instrRun(20);
    check("R3 code2 1:8", tmrValue, 2);
    cfgRate = 3'd7; writeTmr(8'h00); instrRun(600);
    check("R3 code7 1:256", tmrValue, 2);
    cfgRate = 3'd1; writeTmr(8'h00); instrRun(3);
    check("R3 code1 below ratio", tmrValue, 0);
    instrRun(1);
    check("R3 code1 at ratio", tmrValue, 1);
  endtask

  task automatic test_write_clears_prescaler();
    cfgPreWdt = 1'b0; cfgSrcExt = 1'b0; cfgRate = 3'd1;
    writeTmr(8'h00); instrRun(3);
    writeTmr(8'h40);
    check("R5 load value", tmrValue, 8'h40);
    instrRun(3);
    check("R5 prescaler restarted", tmrValue, 8'h40);
    instrRun(1);
    check("R5 first increment", tmrValue, 8'h41);
  endtask

  task automatic test_write_priority();
    cfgPreWdt = 1'b1; cfgSrcExt = 1'b0;
    writeTmr(8'h10);
    instrTick = 1'b1; tmrWrEn = 1'b1; tmrWrData = 8'h80;
    cycles(1);
    instrTick = 1'b0; tmrWrEn = 1'b0;
    check("R9 write beats tick", tmrValue, 8'h80);
  endtask

  task automatic test_overflow_flag();
    cfgPreWdt = 1'b1; cfgSrcExt = 1'b0;
    ovfWrEn = 1'b1; ovfWrData = 1'b0; cycles(1); ovfWrEn = 1'b0;
    writeTmr(8'hFE);
    instrRun(1);
    check("R8 no flag before wrap", ovfFlag, 0);
    instrRun(1);
    check("R8 wrapped value", tmrValue, 0);
    check("R8 flag on wrap", ovfFlag, 1);
    cycles(4);
    check("R8 flag sticky", ovfFlag, 1);
    ovfWrEn = 1'b1; ovfWrData = 1'b0; cycles(1); ovfWrEn = 1'b0;
    check("R8 flag cleared", ovfFlag, 0);
    writeTmr(8'hFF);
    instrTick = 1'b1; ovfWrEn = 1'b1; ovfWrData = 1'b0;
    cycles(1);
    instrTick = 1'b0; ovfWrEn = 1'b0;
    check("R8 wrap beats clear", ovfFlag, 1);
  endtask

  task automatic test_ext_ignores_instr();
    cfgPreWdt = 1'b1; cfgSrcExt = 1'b1; cfgEdgeFall = 1'b0;
    writeTmr(8'h22);
    instrRun(20);
    check("R10 instrTick ignored", tmrValue, 8'h22);
  endtask

  task automatic test_ext_edges();
    cfgPreWdt = 1'b1; cfgSrcExt = 1'b1; cfgEdgeFall = 1'b0;
    writeTmr(8'h00);
    extPin = 1'b1;
    cycles(2);
    check("R7 sync latency hold", tmrValue, 0);
    cycles(1);
    check("R7 rising counted", tmrValue, 1);
    cycles(2);
    extPin = 1'b0; cycles(5);
    check("R7 falling not counted", tmrValue, 1);
    for (int i = 0; i < 2; i++) begin
      extPin = 1'b1; cycles(4);
      extPin = 1'b0; cycles(4);
    end
    check("R7 three rising", tmrValue, 3);
    cfgEdgeFall = 1'b1;
    writeTmr(8'h00);
    for (int i = 0; i < 3; i++) begin
      extPin = 1'b1; cycles(4);
      check("R7 rising ignored in falling mode", tmrValue, i);
      extPin = 1'b0; cycles(4);
    end
    check("R7 three falling", tmrValue, 3);
    cfgSrcExt = 1'b0;
  endtask

  task automatic test_watchdog();
    int p;
    cfgPreWdt = 1'b0;
    clearWdt();
    wdtRun(255, p); check("R4 no timeout before 256", p, 0);
    wdtRun(1, p);   check("R4 timeout at 256", p, 1);
    cycles(1);      check("R4 pulse one cycle", wdtTimeout, 0);
    wdtRun(256, p); check("R4 restart period", p, 1);
    cfgPreWdt = 1'b1; cfgRate = 3'd1;
    clearWdt();
    wdtRun(511, p); check("R4 owner code1 early", p, 0);
    wdtRun(1, p);   check("R4 owner code1 at 512", p, 1);
  endtask

  task automatic test_watchdog_clear();
    int p;
    int q;
    cfgPreWdt = 1'b0;
    clearWdt();
    wdtRun(200, p);
    clearWdt();
    wdtRun(200, q);
    check("R6 clear restarts count", p + q, 0);
    wdtRun(56, p);
    check("R6 timeout after clear", p, 1);
    cfgPreWdt = 1'b1; cfgRate = 3'd1;
    clearWdt();
    wdtRun(1, p);
    clearWdt();
    wdtRun(511, p);
    check("R6 prescaler cleared", p, 0);
    wdtRun(1, p);
    check("R6 full period after clear", p, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; cfgSrcExt = 1'b0; cfgEdgeFall = 1'b0; cfgPreWdt = 1'b1;
    cfgRate = 3'd0; instrTick = 1'b0; extPin = 1'b0; wdtTick = 1'b0;
    tmrWrEn = 1'b0; tmrWrData = 8'h00; ovfWrEn = 1'b0; ovfWrData = 1'b0;
    wdtClr = 1'b0;
    cycles(3);
    test_reset();
    rstN = 1'b1;
    cycles(1);
    test_reset();
    test_direct_count();
    test_timer_ratio();
    test_write_clears_prescaler();
    test_write_priority();
    test_overflow_flag();
    test_ext_ignores_instr();
    test_ext_edges();
    test_watchdog();
    test_watchdog_clear();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule